// File: doc/BRIEF.md
# Buffered Flash Program Engine

This block writes a run of 32-bit words into a parallel NOR flash built from two 16-bit devices side by side, using the devices' internal write buffer. A run is given as a start word address and a word count. The data words then arrive on a valid/ready stream. The engine first collects the whole run into local storage. It reads back the current flash contents and refuses the run if any word would need a bit to go from 0 to 1. Only after that does it start programming. It splits the run into bursts that never straddle a write-buffer boundary. For each burst it requests buffer mode, loads a word count and the data, confirms, and polls status until both devices report ready.

Every command byte is copied into both 16-bit halves of the bus word, so one write reaches both devices. The programming-voltage enable rises before the first program command and falls as the run ends, whatever the outcome. A run that reached the programming stage always ends with a clear-status command and then a return to array-read mode. The run ends with a one-cycle done pulse. That pulse carries the number of words programmed, the last status word read, one fault flag for each device, and flags for a needs-erase refusal, a timeout and a program fault.

Top module: `flash_wbuf_prog`

## Requirements
- R1: `in_ready_o` is high only while the run is being collected, and it stays low while any flash bus cycle is in progress. Exactly `word_cnt_i` words are accepted per run, however long `in_valid_i` stays high.
- R2: If any word fails (new AND current) == new against the flash contents, the run ends with `err_erase_o`. In that case there is no flash write cycle, `vpp_en_o` never rises and `done_words_o` is 0.
- R3: The first burst holds WB_WORDS − (start address mod WB_WORDS) words, or fewer if the run is shorter. Each later burst holds WB_WORDS words, except possibly the last one, which holds the remainder.
- R4: Each burst starts by writing 0x00E800E8 to the block base address (start address with its low log2(BLK_WORDS) bits cleared) and then reading that address. Both steps repeat until bit 7 and bit 23 of the read are both set.
- R5: If buffer mode is not granted within TIMEOUT_CYC cycles, the engine writes 0x00700070 to the block base and reads it. It reports that read on `done_status_o` and raises `err_timeout_o`.
- R6: After the grant, the engine writes (burst length − 1) into both halves at the block base. It then writes the burst's words to consecutive addresses and finally writes 0x00D000D0 to the block base.
- R7: After the confirm, the engine reads the block base until bits 7 and 23 are both set. If TIMEOUT_CYC cycles pass first, it raises `err_timeout_o` and abandons the remaining bursts.
- R8: A ready status with any of bits 1, 3, 4 or 5 set in a half raises `err_prog_o` and abandons the remaining bursts. `err_bank_o[0]` reflects the low half and `err_bank_o[1]` the high half of `done_status_o`.
- R9: Every run that reached programming ends with the write 0x00500050 and then 0x00FF00FF to the block base. This holds on success, on a status fault and on either timeout.
- R10: `vpp_en_o` is high on every flash write cycle. It is low while the engine is idle and during the done pulse.
- R11: `done_o` is a one-cycle pulse. On success `done_words_o` equals the word count. A count of 0 finishes without any bus cycle, and `done_words_o` counts only bursts that ended with a clean status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken when idle) |
| start_addr_i | input | ADDR_W | First word address of the run |
| word_cnt_i | input | clog2(MAX_RUN+1) | Number of words, 0..MAX_RUN |
| in_valid_i | input | 1 | Data word valid |
| in_data_i | input | 32 | Data word |
| in_ready_o | output | 1 | Data word accepted |
| fl_we_o | output | 1 | Flash write cycle |
| fl_rd_o | output | 1 | Flash read cycle, data sampled at the same edge |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_wdata_o | output | 32 | Flash write data |
| fl_rdata_i | input | 32 | Flash read data |
| vpp_en_o | output | 1 | Programming-voltage enable |
| done_o | output | 1 | Run finished (one cycle) |
| done_words_o | output | clog2(MAX_RUN+1) | Words programmed with clean status |
| done_status_o | output | 32 | Last status word read |
| err_erase_o | output | 1 | Run refused: needs erase |
| err_timeout_o | output | 1 | Buffer grant or ready poll timed out |
| err_prog_o | output | 1 | Status reported a fault |
| err_bank_o | output | 2 | Fault per device, bit 0 = low half |

## Verification
The runs start at unaligned, aligned and last-in-buffer addresses. An engine that sizes the first burst from the count rather than from the address would emit a wrong count word and write past a buffer boundary. One test refuses several buffer requests per burst, and a design that moves on before both ready bits are set would emit its count word too early. One test plants a single word that needs a 0-to-1 change late in the run; an engine that checks word by word while programming would leave writes on the bus. Status faults in each half and both timeouts are injected. The bench checks that the clear/reset tail still appears, that the voltage enable drops, and that a faulty first burst is not counted as written.

// File: rtl/flash_wbuf_pkg.sv
package flash_wbuf_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_CHECK, S_REQ, S_XSR, S_CNT, S_DATA,
        S_CONF, S_POLL, S_TOCMD, S_TORD, S_CLR, S_RST, S_DONE
    } fwp_state_e;

    typedef struct packed {
        logic erase;
        logic tmo;
        logic prog;
    } fwp_err_t;

    localparam logic [7:0] CMD_BUFREQ  = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_RDSTAT  = 8'h70;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [15:0] FAULT_MASK = 16'h003A;

    function automatic logic [31:0] mirror8(input logic [7:0] c);
        return {8'h00, c, 8'h00, c};
    endfunction

    function automatic logic both_ready(input logic [31:0] s);
        return s[7] & s[23];
    endfunction

    function automatic logic half_fault(input logic [15:0] h);
        return |(h & FAULT_MASK);
    endfunction

endpackage

// File: rtl/fwp_word_store.sv
module fwp_word_store #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fwp_wait_timer.sv
module fwp_wait_timer #(
    parameter int unsigned LIMIT = 200_000_000,
    localparam int unsigned TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)                      cnt <= '0;
        else if (run && cnt != TW'(LIMIT))   cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TW'(LIMIT));
endmodule

// File: rtl/flash_wbuf_prog.sv
module flash_wbuf_prog
    import flash_wbuf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned WB_WORDS    = 8,
    parameter int unsigned BLK_WORDS   = 64,
    parameter int unsigned MAX_RUN     = 32,
    parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic [ADDR_W-1:0]              start_addr_i,
    input  logic [$clog2(MAX_RUN+1)-1:0]   word_cnt_i,
    input  logic                           in_valid_i,
    input  logic [31:0]                    in_data_i,
    output logic                           in_ready_o,
    output logic                           fl_we_o,
    output logic                           fl_rd_o,
    output logic [ADDR_W-1:0]              fl_addr_o,
    output logic [31:0]                    fl_wdata_o,
    input  logic [31:0]                    fl_rdata_i,
    output logic                           vpp_en_o,
    output logic                           done_o,
    output logic [$clog2(MAX_RUN+1)-1:0]   done_words_o,
    output logic [31:0]                    done_status_o,
    output logic                           err_erase_o,
    output logic                           err_timeout_o,
    output logic                           err_prog_o,
    output logic [1:0]                     err_bank_o
);
    localparam int unsigned CW  = $clog2(MAX_RUN + 1);
    localparam int unsigned IW  = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;
    localparam int unsigned BW  = $clog2(WB_WORDS + 1);
    localparam int unsigned WBB = $clog2(WB_WORDS);
    localparam int unsigned BKB = $clog2(BLK_WORDS);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_WORDS - 1);

    fwp_state_e          state;
    fwp_err_t            err;
    logic [ADDR_W-1:0]   base_addr, cur_addr;
    logic [CW-1:0]       total, idx, ptr, words;
    logic [BW-1:0]       burst_len, beat, len_next;
    logic [31:0]         status;
    logic                vpp;
    logic [31:0]         buf_rd;
    logic                tmr_exp, tmr_run, tmr_clr;
    logic [15:0]         cnt16;

    // run storage: written while collecting, read for the check and the bursts
    fwp_word_store #(.DEPTH(MAX_RUN)) u_store (
        .clk     (clk),
        .wr_en   (state == S_LOAD && in_valid_i),
        .wr_idx  (idx[IW-1:0]),
        .wr_data (in_data_i),
        .rd_idx  ((state == S_CHECK) ? idx[IW-1:0] : ptr[IW-1:0]),
        .rd_data (buf_rd)
    );

    assign tmr_run = (state == S_REQ) || (state == S_XSR) || (state == S_POLL);
    assign tmr_clr = !tmr_run || (state == S_POLL && both_ready(fl_rdata_i));

    fwp_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .expired(tmr_exp)
    );

    // next burst: room left in the current buffer window, capped by what remains
    always_comb begin
        int unsigned room, rem;
        room = WB_WORDS - int'(cur_addr[WBB-1:0]);
        rem  = int'(total) - int'(ptr);
        len_next = BW'((rem < room) ? rem : room);
    end

    assign cnt16 = 16'(burst_len) - 16'd1;

    always_comb begin
        fl_we_o    = 1'b0;
        fl_rd_o    = 1'b0;
        fl_addr_o  = base_addr;
        fl_wdata_o = '0;
        in_ready_o = 1'b0;
        unique case (state)
            S_LOAD:  in_ready_o = 1'b1;
            S_CHECK: begin fl_rd_o = 1'b1; fl_addr_o = cur_addr + ADDR_W'(idx); end
            S_REQ:   begin fl_we_o = 1'b1; fl_wdata_o = mirror8(CMD_BUFREQ); end
            S_XSR, S_POLL, S_TORD: fl_rd_o = 1'b1;
            S_CNT:   begin fl_we_o = 1'b1; fl_wdata_o = {cnt16, cnt16}; end
            S_DATA:  begin fl_we_o = 1'b1; fl_addr_o = cur_addr; fl_wdata_o = buf_rd; end
            S_CONF:  begin fl_we_o = 1'b1; fl_wdata_o = mirror8(CMD_CONFIRM); end
            S_TOCMD: begin fl_we_o = 1'b1; fl_wdata_o = mirror8(CMD_RDSTAT); end
            S_CLR:   begin fl_we_o = 1'b1; fl_wdata_o = mirror8(CMD_CLRSTAT); end
            S_RST:   begin fl_we_o = 1'b1; fl_wdata_o = mirror8(CMD_ARRAY); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            err       <= '0;
            base_addr <= '0;
            cur_addr  <= '0;
            total     <= '0;
            idx       <= '0;
            ptr       <= '0;
            words     <= '0;
            burst_len <= '0;
            beat      <= '0;
            status    <= '0;
            vpp       <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start_i) begin
                    base_addr <= start_addr_i & BLK_MASK;
                    cur_addr  <= start_addr_i;
                    total     <= word_cnt_i;
                    idx       <= '0;
                    ptr       <= '0;
                    words     <= '0;
                    err       <= '0;
                    status    <= '0;
                    state     <= (word_cnt_i == '0) ? S_DONE : S_LOAD;
                end
                S_LOAD: if (in_valid_i) begin
                    idx   <= (idx == total - 1'b1) ? '0 : idx + 1'b1;
                    state <= (idx == total - 1'b1) ? S_CHECK : S_LOAD;
                end
                S_CHECK: begin
                    idx <= idx + 1'b1;
                    if ((buf_rd & ~fl_rdata_i) != '0) begin
                        err.erase <= 1'b1;
                        state     <= S_DONE;
                    end else if (idx == total - 1'b1) begin
                        vpp       <= 1'b1;
                        burst_len <= len_next;
                        state     <= S_REQ;
                    end
                end
                S_REQ: state <= S_XSR;
                S_XSR: begin
                    if (both_ready(fl_rdata_i)) state <= S_CNT;
                    else if (tmr_exp)           state <= S_TOCMD;
                    else                        state <= S_REQ;
                end
                S_CNT: begin beat <= burst_len; state <= S_DATA; end
                S_DATA: begin
                    cur_addr <= cur_addr + 1'b1;
                    ptr      <= ptr + 1'b1;
                    beat     <= beat - 1'b1;
                    if (beat == BW'(1)) state <= S_CONF;
                end
                S_CONF: state <= S_POLL;
                S_POLL: begin
                    if (both_ready(fl_rdata_i)) begin
                        status <= fl_rdata_i;
                        if (half_fault(fl_rdata_i[15:0]) || half_fault(fl_rdata_i[31:16])) begin
                            err.prog <= 1'b1;
                            state    <= S_CLR;
                        end else begin
                            words <= words + CW'(burst_len);
                            if (ptr == total) state <= S_CLR;
                            else begin
                                burst_len <= len_next;
                                state     <= S_REQ;
                            end
                        end
                    end else if (tmr_exp) begin
                        status  <= fl_rdata_i;
                        err.tmo <= 1'b1;
                        state   <= S_CLR;
                    end
                end
                S_TOCMD: state <= S_TORD;
                S_TORD: begin
                    status  <= fl_rdata_i;
                    err.tmo <= 1'b1;
                    state   <= S_CLR;
                end
                S_CLR: state <= S_RST;
                S_RST: begin vpp <= 1'b0; state <= S_DONE; end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign vpp_en_o      = vpp;
    assign done_o        = (state == S_DONE);
    assign done_words_o  = words;
    assign done_status_o = status;
    assign err_erase_o   = err.erase;
    assign err_timeout_o = err.tmo;
    assign err_prog_o    = err.prog;
    assign err_bank_o    = {half_fault(status[31:16]), half_fault(status[15:0])};

    // R10: no write cycle without the programming voltage
    a_r10_vpp_on_write: assert property (@(posedge clk) disable iff (rst)
        fl_we_o |-> vpp_en_o);
    // R10: voltage dropped by the time the run reports
    a_r10_vpp_off_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !vpp_en_o);
    // R1: stream stalled whenever the flash bus is busy
    a_r1_stall_on_bus: assert property (@(posedge clk) disable iff (rst)
        in_ready_o |-> !(fl_we_o || fl_rd_o));
    // R2: a refused run never writes
    a_r2_no_write_refused: assert property (@(posedge clk) disable iff (rst)
        err.erase |-> !fl_we_o);
    // R3: a burst never continues past the last word of a buffer window
    a_r3_window_end: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA && fl_addr_o[WBB-1:0] == WBB'(WB_WORDS - 1)) |=> (state != S_DATA));
    // R6: the confirm follows the data words directly
    a_r6_confirm_after_data: assert property (@(posedge clk) disable iff (rst)
        (state == S_CONF) |-> ($past(state) == S_DATA));
    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // bus strobes are exclusive
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(fl_we_o && fl_rd_o));
    // R4/R6: command cycles stay inside the block
    a_r4_block_base: assert property (@(posedge clk) disable iff (rst)
        (fl_we_o && state != S_DATA) |-> (fl_addr_o[BKB-1:0] == '0));
endmodule

// File: tb/flash_wbuf_prog_tb_top.sv
module flash_wbuf_prog_tb_top;
    localparam int WB  = 8;
    localparam int BLK = 64;
    localparam int TMO = 40;
    localparam logic [15:0] BASE = 16'h0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        start_i = 1'b0;
    logic [15:0] start_addr_i = '0;
    logic [5:0]  word_cnt_i = '0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_data_i = '0;
    logic        in_ready_o, fl_we_o, fl_rd_o, vpp_en_o, done_o;
    logic [15:0] fl_addr_o;
    logic [31:0] fl_wdata_o, fl_rdata_i, done_status_o;
    logic [5:0]  done_words_o;
    logic        err_erase_o, err_timeout_o, err_prog_o;
    logic [1:0]  err_bank_o;

    flash_wbuf_prog #(.ADDR_W(16), .WB_WORDS(WB), .BLK_WORDS(BLK), .MAX_RUN(32),
                      .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .word_cnt_i(word_cnt_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .fl_we_o(fl_we_o), .fl_rd_o(fl_rd_o),
        .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i),
        .vpp_en_o(vpp_en_o), .done_o(done_o), .done_words_o(done_words_o),
        .done_status_o(done_status_o), .err_erase_o(err_erase_o),
        .err_timeout_o(err_timeout_o), .err_prog_o(err_prog_o), .err_bank_o(err_bank_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural flash pair ----------------
    logic [31:0] fmem   [BLK];
    logic [31:0] oldmem [BLK];
    logic [31:0] expmem [BLK];
    logic [31:0] newd   [32];
    int  m_mode, m_left, m_busy, deny_left;
    bit  m_grant;
    int  deny_cfg = 0, busy_cfg = 0;
    bit  nogrant_cfg = 0;
    logic [31:0] inj_cfg = '0;
    bit  mdl_clr = 0;

    always @(posedge clk) begin
        if (mdl_clr) begin
            m_mode <= 0; m_grant <= 0; m_left <= 0; m_busy <= 0; deny_left <= deny_cfg;
            for (int i = 0; i < BLK; i++) fmem[i] <= oldmem[i];
        end else begin
            if (m_mode == 4 && m_busy > 0) m_busy <= m_busy - 1;
            if (fl_we_o) begin
                if (m_mode == 1 && m_grant) begin
                    m_left <= int'(fl_wdata_o[15:0]) + 1;
                    m_mode <= 2;
                end else if (m_mode == 2) begin
                    fmem[fl_addr_o[5:0]] <= fmem[fl_addr_o[5:0]] & fl_wdata_o;
                    if (m_left == 1) m_mode <= 3;
                    m_left <= m_left - 1;
                end else begin
                    case (fl_wdata_o[7:0])
                        8'hE8: begin
                            m_mode <= 1;
                            if (nogrant_cfg || deny_left > 0) begin
                                m_grant <= 0;
                                if (deny_left > 0) deny_left <= deny_left - 1;
                            end else begin
                                m_grant <= 1;
                                deny_left <= deny_cfg;
                            end
                        end
                        8'hD0: begin m_mode <= 4; m_busy <= busy_cfg; end
                        8'h70: begin m_mode <= 4; m_busy <= 0; end
                        8'hFF: m_mode <= 0;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (m_mode)
            0:       fl_rdata_i = fmem[fl_addr_o[5:0]];
            1:       fl_rdata_i = m_grant ? 32'h0080_0080 : 32'h0;
            4:       fl_rdata_i = (m_busy > 0) ? 32'h0 : (32'h0080_0080 | inj_cfg);
            default: fl_rdata_i = 32'h0;
        endcase
    end

    // ---------------- expected write transcript, compared every clock ----------------
    logic [15:0] exp_a [$];
    logic [31:0] exp_d [$];
    int  e8_cnt = 0;
    bit  vpp_seen = 0;
    bit  mon_on = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (in_ready_o && (fl_we_o || fl_rd_o)) begin
                fails++; $display("FAIL R1 in_ready=1 during bus cycle actual=1 expected=0");
            end
            if (fl_we_o && !vpp_en_o) begin
                fails++; $display("FAIL R10 write without vpp actual=0 expected=1");
            end
            if (done_o && vpp_en_o) begin
                fails++; $display("FAIL R10 vpp high at done actual=1 expected=0");
            end
            if (vpp_en_o) vpp_seen = 1;
            if (fl_we_o) begin
                if (exp_a.size() > 0 && exp_a[0] == fl_addr_o && exp_d[0] == fl_wdata_o) begin
                    checks++;
                    void'(exp_a.pop_front()); void'(exp_d.pop_front());
                end else if (fl_addr_o == BASE && fl_wdata_o == 32'h00E8_00E8) begin
                    e8_cnt++;
                end else begin
                    checks++; fails++;
                    $display("FAIL R6 write actual=%h@%h expected=%h@%h", fl_wdata_o, fl_addr_o,
                             (exp_d.size() > 0) ? exp_d[0] : 32'hx,
                             (exp_a.size() > 0) ? exp_a[0] : 16'hx);
                end
            end
        end
    end

    function automatic int offs(input int a);
        return a - int'(BASE);
    endfunction

    task automatic run_case(input string name, input logic [15:0] sa, input int n,
                            input int deny, input bit nogrant, input int busy,
                            input logic [31:0] inj, input bit gaps, input int bad);
        int ptr, a, len, nb, exp_e8, k, acc, cyc;
        bit first_only, ok, seen;
        logic [31:0] exp_stat;
        int exp_words, memerr;
        $display("case %s", name);
        first_only = (inj != 0) || (busy > TMO);
        for (int i = 0; i < BLK; i++) oldmem[i] = (i % 5 == 2) ? 32'hF7FF_FFEF : 32'hFFFF_FFFF;
        for (int j = 0; j < 32; j++) newd[j] = 32'h0;
        for (int j = 0; j < n; j++)
            newd[j] = oldmem[offs(int'(sa) + j)] & {16'hA5C3 ^ 16'(j * 16'h0111), 16'h3C10 + 16'(j)};
        if (bad >= 0) begin
            oldmem[offs(int'(sa) + bad)] = 32'h0000_FFFF;
            newd[bad] = 32'h0001_0000;
        end
        for (int i = 0; i < BLK; i++) expmem[i] = oldmem[i];
        exp_a.delete(); exp_d.delete();
        ptr = 0; a = int'(sa); nb = 0;
        if (n > 0 && bad < 0 && !nogrant) begin
            while (ptr < n) begin
                len = WB - (a % WB);
                if (len > n - ptr) len = n - ptr;
                exp_a.push_back(BASE); exp_d.push_back({16'(len - 1), 16'(len - 1)});
                for (int j = 0; j < len; j++) begin
                    exp_a.push_back(16'(a + j)); exp_d.push_back(newd[ptr + j]);
                    expmem[offs(a + j)] = newd[ptr + j];
                end
                exp_a.push_back(BASE); exp_d.push_back(32'h00D0_00D0);
                nb++; ptr += len; a += len;
                if (first_only) break;
            end
        end
        if (n > 0 && bad < 0 && nogrant) begin exp_a.push_back(BASE); exp_d.push_back(32'h0070_0070); end
        if (n > 0 && bad < 0) begin
            exp_a.push_back(BASE); exp_d.push_back(32'h0050_0050);
            exp_a.push_back(BASE); exp_d.push_back(32'h00FF_00FF);
        end
        exp_e8 = nogrant ? -1 : nb * (deny + 1);
        if (n == 0 || bad >= 0) exp_stat = 32'h0;
        else if (nogrant)       exp_stat = 32'h0080_0080;
        else if (busy > TMO)    exp_stat = 32'h0;
        else                    exp_stat = 32'h0080_0080 | inj;
        exp_words = (n > 0 && bad < 0 && !nogrant && !first_only) ? n : 0;

        deny_cfg = deny; nogrant_cfg = nogrant; busy_cfg = busy; inj_cfg = inj;
        @(negedge clk); mdl_clr = 1;
        @(negedge clk); mdl_clr = 0;
        e8_cnt = 0; vpp_seen = 0;
        start_i = 1; start_addr_i = sa; word_cnt_i = 6'(n);
        @(negedge clk); start_i = 0;
        k = 0; acc = 0; cyc = 0; seen = 0;
        while (!seen && cyc < 3000) begin
            if (done_o) begin
                seen = 1;
                chk("R11 done_words", 32'(done_words_o), 32'(exp_words));
                chk("R8 status", done_status_o, exp_stat);
                chk("R2 err_erase", 32'(err_erase_o), 32'(bad >= 0));
                chk("R5/R7 err_timeout", 32'(err_timeout_o), 32'(nogrant || busy > TMO));
                chk("R8 err_prog", 32'(err_prog_o), 32'(inj != 0 && !nogrant));
                chk("R8 err_bank", 32'(err_bank_o),
                    32'({|(exp_stat[31:16] & 16'h003A), |(exp_stat[15:0] & 16'h003A)}));
                chk("R10 vpp off at done", 32'(vpp_en_o), 32'h0);
            end else begin
                in_valid_i = gaps ? (cyc % 3 != 1) : 1'b1;
                in_data_i  = (k < n) ? newd[k] : 32'hDEAD_BEEF;
                if (in_valid_i && in_ready_o) begin acc++; if (k < n) k++; end
                @(negedge clk);
                cyc++;
            end
        end
        in_valid_i = 0;
        if (!seen) begin fails++; checks++; $display("FAIL R11 no done in case %s actual=0 expected=1", name); end
        chk("R1 words accepted", 32'(acc), 32'(n));
        chk("R6 transcript drained", 32'(exp_a.size()), 32'h0);
        if (exp_e8 >= 0) chk("R4 buffer requests", 32'(e8_cnt), 32'(exp_e8));
        if (bad >= 0 || n == 0) chk("R2 vpp never raised", 32'(vpp_seen), 32'h0);
        memerr = 0;
        for (int i = 0; i < BLK; i++) if (fmem[i] !== expmem[i]) memerr++;
        chk("R3 flash contents", 32'(memerr), 32'h0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 reset done", 32'(done_o), 32'h0);
        chk("R10 reset vpp", 32'(vpp_en_o), 32'h0);
        chk("R1 reset ready", 32'(in_ready_o), 32'h0);
        chk("R9 reset bus", 32'({fl_we_o, fl_rd_o}), 32'h0);
        mon_on = 1;
        // R3: unaligned start, bursts 5 then 7
        run_case("unaligned", 16'h0103, 12, 0, 0, 3, 32'h0, 0, -1);
        // R4: refused requests, aligned start, bursts 8/8/4, gappy stream
        run_case("denied", 16'h0108, 20, 2, 0, 2, 32'h0, 1, -1);
        // R3: single word at the last slot of a window
        run_case("last_slot", 16'h010F, 1, 0, 0, 1, 32'h0, 0, -1);
        // R2: one word needs a 0-to-1 change
        run_case("needs_erase", 16'h0104, 10, 0, 0, 1, 32'h0, 0, 7);
        // R5: buffer never granted
        run_case("grant_timeout", 16'h0100, 4, 0, 1, 1, 32'h0, 0, -1);
        // R8: high-half program fault after the first burst
        run_case("fault_high", 16'h0103, 12, 0, 0, 2, 32'h0010_0000, 0, -1);
        // R8: low-half lock fault
        run_case("fault_low", 16'h0120, 3, 0, 0, 2, 32'h0000_0002, 0, -1);
        // R7: device stays busy past the limit
        run_case("poll_timeout", 16'h0102, 9, 0, 0, 1000, 32'h0, 0, -1);
        // R11: zero-length run
        run_case("zero", 16'h0110, 0, 0, 0, 1, 32'h0, 0, -1);
        // R9: full-size run, four full bursts
        run_case("full", 16'h0100, 32, 1, 0, 4, 32'h0, 1, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule